// File: doc/BRIEF.md
# Adjacent-Line Pair Prefetcher

This block sits beside a second-level cache and listens to its demand misses. Each miss names a 64-byte line, and that line always has a partner: the other half of the 128-byte-aligned region that holds it. The block works out the partner's line address and sends it to the tag array as a presence probe. If the partner is not resident, not already waiting in the block's request queue, and the cache is not already busy with too many misses, the partner's address goes into a small request queue.

The queue presents prefetch requests on a valid/ready port in the order they were accepted. A single miss is enough to start a prefetch, because no access history is kept. The request leaves one cycle after the miss, so its fill can overlap the demand fill. When the queue is full, a new candidate is discarded and nothing is held back.

Top module: `pair_prefetcher`

## Requirements
- R1: The probe address and the prefetch address are the partner of the missing line. Address bit 6 is inverted, bits above 6 are copied, and bits 5..0 are zero. The partner can lie below the missing line.
- R2: When a miss is accepted and the queue is empty, `pf_valid_o` is high in the cycle after the clock edge that sampled the miss. A single miss is enough, with no earlier miss needed.
- R3: No candidate is queued when `miss_inflight_i` is greater than or equal to THROTTLE (default 4). At THROTTLE-1 the candidate is queued.
- R4: No candidate is queued when `probe_hit_i` is high in the same cycle as the miss.
- R5: No candidate is queued when its line address equals an entry already in the queue. This includes the entry being handed off in that same cycle.
- R6: The queue holds at most DEPTH (default 4) entries. A candidate that arrives while DEPTH entries are held is discarded, even if one leaves in that cycle.
- R7: While `pf_valid_o` is high and `pf_ready_i` is low, `pf_valid_o` stays high and `pf_addr_o` does not change.
- R8: Requests leave in the order they were queued.
- R9: After reset, `pf_valid_o` is low and the queue is empty. No candidate is queued in a cycle where `miss_vld_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_vld_i | input | 1 | A demand miss is present this cycle |
| miss_addr_i | input | ADDR_W (32) | Byte address of the demand miss |
| miss_inflight_i | input | INFL_W (4) | Number of misses currently outstanding at the cache |
| probe_addr_o | output | ADDR_W (32) | Partner line address sent to the tag array |
| probe_hit_i | input | 1 | Tag array reports the partner line as resident, in the same cycle |
| pf_valid_o | output | 1 | A prefetch request is presented |
| pf_ready_i | input | 1 | Downstream accepts the presented request |
| pf_addr_o | output | ADDR_W (32) | Line-aligned prefetch address |

## Verification
The bench sends misses whose partner lies above the missing line and misses whose partner lies below it. A design that always adds one line would send the wrong address for the second kind. It probes the throttle at exactly THROTTLE and at one below, which catches an off-by-one compare. It sends a repeat miss to a partner that is still queued, which a design without the queue match would send twice. It fills the queue with `pf_ready_i` held low, so an overrun would overwrite the oldest entry and the drain order would come out wrong. It also watches that the presented address holds still while stalled.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Why a miss did or did not yield a queued candidate.
  typedef enum logic [2:0] {
    PF_TAKE      = 3'd0,
    PF_NO_MISS   = 3'd1,
    PF_THROTTLED = 3'd2,
    PF_RESIDENT  = 3'd3,
    PF_QUEUED    = 3'd4,
    PF_NO_ROOM   = 3'd5
  } pf_verdict_e;

endpackage

// File: rtl/pf_partner.sv
module pf_partner #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input  logic [ADDR_W-OFF_W-1:0] line_i,
  output logic [ADDR_W-OFF_W-1:0] partner_o
);

  localparam int LINE_W = ADDR_W - OFF_W;

  // Lowest bit of the line number selects the half of the aligned pair.
  always_comb begin
    partner_o    = line_i;
    partner_o[0] = ~line_i[0];
  end

  initial begin
    assert (LINE_W >= 2) else $error("address too narrow for line pairs");
  end

endmodule

// File: rtl/pf_filter.sv
module pf_filter
  import pf_pkg::*;
#(
  parameter int INFL_W   = 4,
  parameter int THROTTLE = 4
) (
  input  logic              miss_vld_i,
  input  logic [INFL_W-1:0] inflight_i,
  input  logic              resident_i,
  input  logic              queued_i,
  input  logic              full_i,
  output logic              take_o
);

  localparam logic [INFL_W-1:0] LIMIT = INFL_W'(THROTTLE);

  pf_verdict_e verdict;

  // Priority order: no miss, busy cache, already resident, already queued, no room.
  always_comb begin
    if (!miss_vld_i)              verdict = PF_NO_MISS;
    else if (inflight_i >= LIMIT) verdict = PF_THROTTLED;
    else if (resident_i)          verdict = PF_RESIDENT;
    else if (queued_i)            verdict = PF_QUEUED;
    else if (full_i)              verdict = PF_NO_ROOM;
    else                          verdict = PF_TAKE;
  end

  assign take_o = (verdict == PF_TAKE);

  initial begin
    assert (THROTTLE < (1 << INFL_W)) else $error("THROTTLE does not fit INFL_W");
  end

endmodule

// File: rtl/pf_queue.sv
module pf_queue #(
  parameter int LINE_W = 26,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [LINE_W-1:0] push_line_i,
  input  logic [LINE_W-1:0] cand_line_i,
  output logic              match_o,
  output logic              full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [LINE_W-1:0] out_line_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [LINE_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  occ_q, occ_d;
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [DEPTH-1:0]  hit_vec;
  logic              pop;

  // Compare the candidate against every held slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit_vec[g] = occ_q[g] && (slot_q[g] == cand_line_i);
  end

  assign match_o     = |hit_vec;
  assign full_o      = &occ_q;
  assign count_o     = CNT_W'($countones(occ_q));
  assign out_valid_o = occ_q[rd_q];
  assign out_line_o  = slot_q[rd_q];
  assign pop         = out_valid_o && out_ready_i;

  always_comb begin
    occ_d = occ_q;
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (pop) begin
      occ_d[rd_q] = 1'b0;
      rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    end
    if (push_i) begin
      occ_d[wr_q] = 1'b1;
      wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      occ_q <= occ_d;
      wr_q  <= wr_d;
      rd_q  <= rd_d;
    end
  end

  // Payload storage: clock-enabled, no reset needed.
  always_ff @(posedge clk) begin
    if (push_i) slot_q[wr_q] <= push_line_i;
  end

  // R6: a push never lands on an occupied slot.
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !occ_q[wr_q]);

  // R7: a stalled request holds its valid and its address.
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_line_o)));

  // R8: after a lone pop, the read pointer moves to the next slot in sequence.
  p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (rd_q != $past(rd_q)));

endmodule

// File: rtl/pair_prefetcher.sv
module pair_prefetcher #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int INFL_W     = 4,
  parameter int THROTTLE   = 4,
  parameter int DEPTH      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_vld_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic [INFL_W-1:0] miss_inflight_i,
  output logic [ADDR_W-1:0] probe_addr_o,
  input  logic              probe_hit_i,
  output logic              pf_valid_o,
  input  logic              pf_ready_i,
  output logic [ADDR_W-1:0] pf_addr_o
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic [LINE_W-1:0] miss_line, partner_line, head_line;
  logic              queued, full, take;
  logic [CNT_W-1:0]  q_count;
  logic              unused_offset;

  assign miss_line     = miss_addr_i[ADDR_W-1:OFF_W];
  assign unused_offset = ^miss_addr_i[OFF_W-1:0];

  pf_partner #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_partner (
    .line_i    (miss_line),
    .partner_o (partner_line)
  );

  assign probe_addr_o = {partner_line, {OFF_W{1'b0}}};

  pf_filter #(
    .INFL_W   (INFL_W),
    .THROTTLE (THROTTLE)
  ) u_filter (
    .miss_vld_i (miss_vld_i),
    .inflight_i (miss_inflight_i),
    .resident_i (probe_hit_i),
    .queued_i   (queued),
    .full_i     (full),
    .take_o     (take)
  );

  pf_queue #(
    .LINE_W (LINE_W),
    .DEPTH  (DEPTH)
  ) u_queue (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push_i      (take),
    .push_line_i (partner_line),
    .cand_line_i (partner_line),
    .match_o     (queued),
    .full_o      (full),
    .count_o     (q_count),
    .out_valid_o (pf_valid_o),
    .out_ready_i (pf_ready_i),
    .out_line_o  (head_line)
  );

  assign pf_addr_o = {head_line, {OFF_W{1'b0}}};

  // R1: the probe names the other half of the same aligned pair.
  p_pair_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    miss_vld_i |-> ((probe_addr_o[OFF_W] != miss_addr_i[OFF_W]) &&
                    (probe_addr_o[ADDR_W-1:OFF_W+1] == miss_addr_i[ADDR_W-1:OFF_W+1])));

  // R2: an accepted miss is presented on the next cycle.
  p_next_cycle_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take |=> pf_valid_o);

  // R3: a busy cache adds nothing to the queue.
  p_throttle_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (miss_inflight_i >= INFL_W'(THROTTLE)) |=> (q_count <= $past(q_count)));

  // R4: a resident partner adds nothing to the queue.
  p_resident_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    probe_hit_i |=> (q_count <= $past(q_count)));

  // R5: a partner already queued is not accepted again.
  p_no_dup_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    queued |-> !take);

  // R9: with no miss, nothing is accepted.
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !miss_vld_i |-> !take);

endmodule

// File: tb/pair_prefetcher_test.sv
module pair_prefetcher_test;

  localparam int CLK_PERIOD = 10;
  localparam int THR        = 4;
  localparam int QDEPTH     = 4;

  logic        clk;
  logic        rst_n;
  logic        miss_vld;
  logic [31:0] miss_addr;
  logic [3:0]  inflight;
  logic [31:0] probe_addr;
  logic        probe_hit;
  logic        pf_valid;
  logic        pf_ready;
  logic [31:0] pf_addr;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  bit done = 0;

  pair_prefetcher uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .miss_vld_i      (miss_vld),
    .miss_addr_i     (miss_addr),
    .miss_inflight_i (inflight),
    .probe_addr_o    (probe_addr),
    .probe_hit_i     (probe_hit),
    .pf_valid_o      (pf_valid),
    .pf_ready_i      (pf_ready),
    .pf_addr_o       (pf_addr)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] partner(input logic [31:0] a);
    return {a[31:7], ~a[6], 6'b0};
  endfunction

  // Driver: present one miss, predict whether it is queued.
  task automatic do_miss(input logic [31:0] a, input int infl, input logic hit);
    logic [31:0] p;
    bit dup;
    @(negedge clk);
    miss_vld  = 1'b1;
    miss_addr = a;
    inflight  = 4'(infl);
    probe_hit = hit;
    p   = partner(a);
    dup = 0;
    foreach (exp_q[i]) if (exp_q[i] == p) dup = 1;
    if (infl < THR && !hit && !dup && exp_q.size() < QDEPTH) exp_q.push_back(p);
    #1;
    check(probe_addr == p, "R1 probe address", probe_addr, p);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      miss_vld  = 1'b0;
      probe_hit = 1'b0;
      inflight  = '0;
    end
  endtask

  // Monitor: compare each handed-off request with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && pf_valid && pf_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R3/R4/R5/R6 unexpected request", pf_addr, 32'h0);
        end else begin
          check(pf_addr == exp_q[0], "R8 order/address", pf_addr, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 0; miss_vld = 0; miss_addr = '0; inflight = '0; probe_hit = 0; pf_ready = 1;
    repeat (3) @(negedge clk);
    check(pf_valid == 1'b0, "R9 reset valid", {31'b0, pf_valid}, 32'h0);
    rst_n = 1;
    idle(4);
    check(pf_valid == 1'b0, "R9 idle after reset", {31'b0, pf_valid}, 32'h0);

    // R1/R2: partner above, then partner below.
    do_miss(32'h0000_1000, 0, 0);
    idle(1);
    check(pf_valid == 1'b1, "R2 next-cycle issue", {31'b0, pf_valid}, 32'h1);
    check(pf_addr == 32'h0000_1040, "R1 partner above", pf_addr, 32'h0000_1040);
    do_miss(32'h0000_2345, 0, 0);
    idle(1);
    check(pf_addr == 32'h0000_2300, "R1 partner below", pf_addr, 32'h0000_2300);
    idle(3);

    // R3: throttle boundary.
    do_miss(32'h0001_0000, THR, 0);
    idle(1);
    check(pf_valid == 1'b0, "R3 throttled at limit", {31'b0, pf_valid}, 32'h0);
    do_miss(32'h0001_0000, THR - 1, 0);
    idle(1);
    check(pf_valid == 1'b1, "R3 accepted below limit", {31'b0, pf_valid}, 32'h1);
    idle(3);

    // R4: resident partner.
    do_miss(32'h0002_0080, 0, 1);
    idle(1);
    check(pf_valid == 1'b0, "R4 resident dropped", {31'b0, pf_valid}, 32'h0);
    idle(2);

    // R5/R6/R7: stall the output and fill the queue.
    pf_ready = 0;
    do_miss(32'h0000_1000, 0, 0);
    do_miss(32'h0000_1010, 0, 0);
    do_miss(32'h0000_5000, 0, 0);
    do_miss(32'h0000_6000, 0, 0);
    do_miss(32'h0000_7000, 0, 0);
    do_miss(32'h0000_8000, 0, 0);
    idle(1);
    check(exp_q.size() == QDEPTH, "R5/R6 model depth", exp_q.size(), QDEPTH);
    held = pf_addr;
    check(held == 32'h0000_1040, "R7 head while stalled", held, 32'h0000_1040);
    idle(3);
    check(pf_valid == 1'b1 && pf_addr == held, "R7 held under stall", pf_addr, held);
    @(negedge clk);
    pf_ready = 1;
    idle(8);
    check(exp_q.size() == 0, "R6 drain count", exp_q.size(), 0);

    // R8: back-to-back misses with continuous ready.
    do_miss(32'h0010_0000, 0, 0);
    do_miss(32'h0020_0040, 0, 0);
    do_miss(32'h0030_0000, 1, 0);
    do_miss(32'h0040_00C0, 2, 0);
    idle(8);
    check(exp_q.size() == 0, "R8 all delivered", exp_q.size(), 0);
    check(pf_valid == 1'b0, "R9 empty at end", {31'b0, pf_valid}, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule